// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block keeps the per-bank view a memory controller needs before it issues a command to a DRAM device. Each bank is either idle (precharged, no row held) or active (one row held in its row buffer). A scheduler presents at most one command per cycle on a shared command bus: precharge, row activate, column read or column write. Each command carries a bank index and a row number. The block decides in the same cycle whether the command is legal. If it is, the bank state is updated at the next clock edge. If it is not, an error pulse is raised and nothing changes.

Precharge and activate keep the bank occupied for a parameterised number of cycles. During that time the bank's ready flag is low and every command to it is refused. A column command must name the row that is currently open. An accepted read produces a one-cycle data-valid strobe for its bank three cycles after issue. An accepted write raises a write-data enable in the issuing cycle, so that the data path drives the write data alongside the command. The scheduler uses the active flags, the open rows and the ready flags to choose its next command.

Top module: `bank_tracker`

## Requirements
- R1: After reset every bank is idle, has open row 0 and is ready, and no read-valid strobe or error is asserted.
- R2: An activate (code 2) to an idle, ready bank is accepted; from the next cycle that bank is active with the command's row as its open row.
- R3: A precharge (code 1) to an active, ready bank is accepted; from the next cycle that bank is idle.
- R4: A read (code 3) or write (code 4) is accepted only when the bank is active, ready, and the command's row equals the bank's open row.
- R5: After an accepted precharge, the bank's ready flag is low for exactly T_PRE cycles (default 3) and then returns high; commands to it are refused while it is low.
- R6: After an accepted activate, the bank's ready flag is low for exactly T_ACT cycles (default 3); the ready flags and states of the other banks are not affected.
- R7: A command that is not legal raises cmd_err in the same cycle and changes no bank state, produces no strobe and no write enable. Codes 5 to 7 are always illegal. A read or write is illegal to an idle bank, to a busy bank, or with a wrong row. An activate is illegal to an active or busy bank. A precharge is illegal to an idle or busy bank.
- R8: For each accepted read issued in cycle t, rd_valid for that bank is high in cycle t+3 only; back-to-back reads give back-to-back strobes.
- R9: wr_data_en is high in exactly the cycle in which a write is accepted.
- R10: A no-operation (code 0) never raises cmd_err and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code: 0 none, 1 precharge, 2 activate, 3 read, 4 write |
| cmd_bank | input | BANK_W (2) | Target bank index |
| cmd_row | input | ROW_W (8) | Row to open (activate) or row expected open (read/write) |
| cmd_err | output | 1 | Command in this cycle is refused |
| wr_data_en | output | 1 | Write accepted this cycle; write data must be driven now |
| bank_active | output | NUM_BANKS (4) | Per-bank active flag |
| bank_ready | output | NUM_BANKS (4) | Per-bank ready flag (busy counter at zero) |
| bank_row | output | NUM_BANKS*ROW_W (32) | Open row of each bank, bank 0 in the low bits |
| rd_valid | output | NUM_BANKS (4) | Per-bank read data-valid strobe |

## Verification
The return strobe of an earlier read can fall in the same cycle as a new command to the same bank. The most searching case is a precharge that closes the row while up to three read strobes for that row are still on their way. The bench issues several reads back to back and then a precharge to the same bank at the earliest legal moment. It also issues commands to other banks while those strobes are still pending. Its reference model keeps the strobes in a queue of due cycles that is separate from the bank state, so it requires the strobes to arrive on time even though the bank has already gone idle. The same model judges, every cycle, each refusal of a command that reaches a bank while an earlier activate or precharge still occupies it.

// File: rtl/bank_pkg.sv
package bank_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  // Number of cycles a command keeps its bank occupied.
  function automatic int unsigned occupy_cycles(input logic [2:0] c,
                                                input int unsigned t_pre,
                                                input int unsigned t_act);
    case (c)
      CMD_PRE: return t_pre;
      CMD_ACT: return t_act;
      default: return 0;
    endcase
  endfunction

  // Legality of a command against one bank's state.
  function automatic logic cmd_allowed(input logic [2:0] c,
                                       input logic active,
                                       input logic ready,
                                       input logic row_hit);
    case (c)
      CMD_PRE: return active && ready;
      CMD_ACT: return !active && ready;
      CMD_RD,
      CMD_WR:  return active && ready && row_hit;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bank_slot.sv
module bank_slot
  import bank_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int T_PRE = 3,
  parameter int T_ACT = 3,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd,
  input  logic [ROW_W-1:0] row_in,
  input  logic             go,
  output logic             legal,
  output logic             active,
  output logic             ready,
  output logic [ROW_W-1:0] open_row
);

  logic [CNT_W-1:0] busy_cnt;
  logic             row_hit;
  logic             go_act;
  logic             go_pre;
  logic             go_col;

  assign row_hit = (row_in == open_row);
  assign legal   = cmd_allowed(cmd, active, ready, row_hit);
  assign ready   = (busy_cnt == '0);
  assign go_act  = go && (cmd == CMD_ACT);
  assign go_pre  = go && (cmd == CMD_PRE);
  assign go_col  = go && ((cmd == CMD_RD) || (cmd == CMD_WR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      open_row <= '0;
      busy_cnt <= '0;
    end else begin
      if (go_act) begin
        active   <= 1'b1;
        open_row <= row_in;
      end else if (go_pre) begin
        active   <= 1'b0;
      end
      if (go_act || go_pre)
        busy_cnt <= CNT_W'(occupy_cycles(cmd, T_PRE, T_ACT));
      else if (busy_cnt != '0)
        busy_cnt <= busy_cnt - 1'b1;
    end
  end

  // R2
  act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_act |=> active && (open_row == $past(row_in)) && !ready);

  // R3
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_pre |=> !active && !ready);

  // R4
  col_row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_col |-> active && ready && (row_in == open_row));

  // R5
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !go);

  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(active) && $stable(open_row));

endmodule

// File: rtl/rd_return_pipe.sv
module rd_return_pipe #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] rd_issue,
  output logic [NUM_BANKS-1:0] rd_done
);

  logic [NUM_BANKS-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= rd_issue;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[k] <= '0;
      else        stage[k] <= stage[k-1];
    end

    // R8
    pipe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> stage[k] == $past(stage[k-1]));
  end

  assign rd_done = stage[DEPTH-1];

  // R8
  one_read_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_issue));

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int T_PRE     = 3,
  parameter int T_ACT     = 3,
  parameter int RD_LAT    = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int T_MAX    = (T_PRE > T_ACT) ? T_PRE : T_ACT,
  localparam int CNT_W    = $clog2(T_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 cmd,
  input  logic [BANK_W-1:0]          cmd_bank,
  input  logic [ROW_W-1:0]           cmd_row,
  output logic                       cmd_err,
  output logic                       wr_data_en,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS-1:0]       bank_ready,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic [NUM_BANKS-1:0]       rd_valid
);

  logic [NUM_BANKS-1:0] sel;
  logic [NUM_BANKS-1:0] legal;
  logic [NUM_BANKS-1:0] accept;
  logic [NUM_BANKS-1:0] rd_issue;
  logic                 any_accept;
  logic                 is_nop;

  assign is_nop = (cmd == CMD_NOP);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel[b]      = !is_nop && (cmd_bank == BANK_W'(b));
    assign accept[b]   = sel[b] && legal[b];
    assign rd_issue[b] = accept[b] && (cmd == CMD_RD);

    bank_slot #(
      .ROW_W (ROW_W),
      .T_PRE (T_PRE),
      .T_ACT (T_ACT),
      .CNT_W (CNT_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .row_in   (cmd_row),
      .go       (accept[b]),
      .legal    (legal[b]),
      .active   (bank_active[b]),
      .ready    (bank_ready[b]),
      .open_row (bank_row[b*ROW_W +: ROW_W])
    );
  end

  assign any_accept = |accept;
  assign cmd_err    = !is_nop && !any_accept;
  assign wr_data_en = any_accept && (cmd == CMD_WR);

  rd_return_pipe #(
    .NUM_BANKS (NUM_BANKS),
    .DEPTH     (RD_LAT)
  ) u_rd_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (rd_issue),
    .rd_done  (rd_valid)
  );

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (accept == '0) && !wr_data_en);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> $stable(bank_active) && $stable(bank_row));

  // R10
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> !cmd_err && !wr_data_en);

  // R9
  wr_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |-> $onehot(accept) && (cmd == CMD_WR));

endmodule

// File: tb/bank_tracker_test.sv
module bank_tracker_test;

  localparam int NB   = 4;
  localparam int RW   = 8;
  localparam int TPRE = 3;
  localparam int TACT = 3;
  localparam int LAT  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      cmd = 3'd0;
  logic [1:0]      cmd_bank = 2'd0;
  logic [RW-1:0]   cmd_row = '0;
  logic            cmd_err;
  logic            wr_data_en;
  logic [NB-1:0]   bank_active;
  logic [NB-1:0]   bank_ready;
  logic [NB*RW-1:0] bank_row;
  logic [NB-1:0]   rd_valid;

  always #5 clk = ~clk;

  bank_tracker #(
    .NUM_BANKS (NB), .ROW_W (RW), .T_PRE (TPRE), .T_ACT (TACT), .RD_LAT (LAT)
  ) uut (
    .clk (clk), .rst_n (rst_n), .cmd (cmd), .cmd_bank (cmd_bank),
    .cmd_row (cmd_row), .cmd_err (cmd_err), .wr_data_en (wr_data_en),
    .bank_active (bank_active), .bank_ready (bank_ready),
    .bank_row (bank_row), .rd_valid (rd_valid)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference model
  int m_act [NB];
  int m_row [NB];
  int m_busy [NB];
  int m_due [NB][$];
  int cyc = 0;
  int p_cmd = 0, p_bank = 0, p_row = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit m_legal(input int c, input int b, input int r);
    if (c == 1) return m_act[b] == 1 && m_busy[b] == 0;
    if (c == 2) return m_act[b] == 0 && m_busy[b] == 0;
    if (c == 3 || c == 4) return m_act[b] == 1 && m_busy[b] == 0 && m_row[b] == r;
    return 1'b0;
  endfunction

  task automatic m_reset();
    for (int b = 0; b < NB; b++) begin
      m_act[b] = 0; m_row[b] = 0; m_busy[b] = 0; m_due[b].delete();
    end
    p_cmd = 0; p_bank = 0; p_row = 0;
  endtask

  task automatic m_edge();
    bit ok;
    ok = m_legal(p_cmd, p_bank, p_row);
    cyc++;
    for (int b = 0; b < NB; b++) begin
      if (m_busy[b] > 0) m_busy[b]--;
      while (m_due[b].size() > 0 && m_due[b][0] < cyc) void'(m_due[b].pop_front());
    end
    if (ok) begin
      case (p_cmd)
        1: begin m_act[p_bank] = 0; m_busy[p_bank] = TPRE; end
        2: begin m_act[p_bank] = 1; m_row[p_bank] = p_row; m_busy[p_bank] = TACT; end
        3: m_due[p_bank].push_back(cyc + LAT - 1);
        default: ;
      endcase
    end
  endtask

  task automatic compare_all(input int c, input int b, input int r);
    bit ok;
    string etag;
    ok = m_legal(c, b, r);
    case (c)
      0: etag = "R10";
      1: etag = "R3/R7";
      2: etag = "R2/R7";
      3, 4: etag = "R4/R7";
      default: etag = "R7";
    endcase
    chk(etag, "cmd_err", int'(cmd_err), int'(c != 0 && !ok));
    chk("R9", "wr_data_en", int'(wr_data_en), int'(c == 4 && ok));
    for (int k = 0; k < NB; k++) begin
      chk("R2/R3", $sformatf("active[%0d]", k), int'(bank_active[k]), m_act[k]);
      chk("R2", $sformatf("row[%0d]", k), int'(bank_row[k*RW +: RW]), m_row[k]);
      chk("R5/R6", $sformatf("ready[%0d]", k), int'(bank_ready[k]), int'(m_busy[k] == 0));
      chk("R8", $sformatf("rd_valid[%0d]", k), int'(rd_valid[k]),
          int'(m_due[k].size() > 0 && m_due[k][0] == cyc));
    end
  endtask

  task automatic step(input int c, input int b, input int r);
    @(negedge clk);
    m_edge();
    cmd = 3'(c); cmd_bank = 2'(b); cmd_row = RW'(r);
    #1;
    compare_all(c, b, r);
    p_cmd = c; p_bank = b; p_row = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1: reset state
    chk("R1", "cmd_err", int'(cmd_err), 0);
    chk("R1", "active", int'(bank_active), 0);
    chk("R1", "ready", int'(bank_ready), 4'hF);
    chk("R1", "rows", int'(bank_row), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    m_reset();

    // directed: illegal column to idle bank (R4, R7)
    step(3, 0, 5);
    step(1, 0, 0);             // precharge of idle bank (R7)
    step(2, 0, 5);             // activate (R2)
    step(3, 0, 5);             // busy (R6, R7)
    step(2, 1, 9);             // other bank unaffected (R6)
    idle(2);
    step(3, 0, 6);             // wrong row (R4)
    step(4, 0, 5);             // write (R9)
    step(3, 0, 5);             // three back-to-back reads (R8)
    step(3, 0, 5);
    step(3, 0, 5);
    step(1, 0, 0);             // precharge while strobes in flight (R3, R5)
    step(2, 0, 7);             // busy after precharge (R5)
    step(5, 2, 0);             // reserved codes (R7)
    step(6, 2, 0);
    step(7, 3, 0);
    idle(4);
    step(2, 0, 7);
    idle(3);
    step(3, 0, 7);
    step(3, 1, 9);
    step(1, 1, 0);
    idle(5);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int c;
      c = (i % 7 == 0) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 4));
      step(c, int'($urandom_range(0, NB - 1)), int'($urandom_range(0, 3)));
    end

    // mid-run reset (R1)
    @(negedge clk);
    rst_n = 1'b0;
    cmd = 3'd0;
    @(negedge clk);
    #1;
    chk("R1", "active after reset", int'(bank_active), 0);
    chk("R1", "ready after reset", int'(bank_ready), 4'hF);
    chk("R1", "rd_valid after reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    m_reset();
    idle(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule